// File: doc/BRIEF.md
# I2C Control-Register Target with Auto-Increment Pointer

This block is a serial-bus target that owns a handful of 8-bit control registers for an amplifier control path. It oversamples SCL and SDA with the system clock and detects start and stop conditions. It checks a 7-bit device address and its direction bit, then takes a register pointer byte. Data bytes that follow are written at the pointer. After a repeated start with the read direction, bytes are read out from the pointer. Each byte moves the pointer forward by one.

The register fields appear as parallel outputs for the analog control logic:
- channel enables
- routing mode
- low-power request
- mutes
- a 6-bit gain code
- output-float requests

A thermal event input sets a sticky flag that clears once it has been read over the bus. A write that requests low power also drops both channel enables. The active-low shutdown input returns the whole bank to its power-on contents.

Top module: `i2c_regbank_target`

## Requirements
- R1: After shutdown is released, register 1 (control) reads 0x00, register 2 (level) reads 0xC0 (both mutes set, gain 0) and register 3 (float) reads 0x00. The parallel outputs match these values.
- R2: A first byte equal to {DEV_ADDR, rw} is acknowledged by pulling SDA low for the ninth clock. The pointer byte and each written data byte are acknowledged the same way. With any other address, SDA stays released until the next start.
- R3: In a write, the second byte sets the pointer. Each further byte is stored at the pointer, and the pointer then steps by one, until a stop or a repeated start.
- R4: After a repeated start with rw=1, bytes come MSB first from the pointer onward. The target keeps sending while the master acknowledges, and releases SDA after a NACK.
- R5: Register 1 bits 3:2 and register 3 bits 7:2 always read 0 and ignore writes.
- R6: Register 4 is read-only and reads {4'b0000, VERSION}. The default VERSION is 4'b0010.
- R7: Writes to pointer 0 or to pointers 5 and above are acknowledged and discarded. Reads there return 0x00.
- R8: A high thermal input sets register 1 bit 1. Writes do not change this bit. It clears after a bus read of register 1, unless the thermal input is high again.
- R9: A write to register 1 with bit 0 (low-power) set stores that bit and forces bits 7 and 6 (left and right enable) to 0.
- R10: While shdn_n is low, every register is held at its reset value.
- R11: Bytes clocked in after a stop and without a new start are not acknowledged and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| shdn_n | input | 1 | Active-low shutdown; asynchronously resets all state |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus) |
| sda_pull_o | output | 1 | 1 = pull SDA low; 0 = release |
| therm_evt_i | input | 1 | Thermal fault indication, sampled each clock |
| amp_en_l_o | output | 1 | Left channel enable (reg 1 bit 7) |
| amp_en_r_o | output | 1 | Right channel enable (reg 1 bit 6) |
| route_mode_o | output | 2 | Routing mode (reg 1 bits 5:4) |
| soft_down_o | output | 1 | Low-power request (reg 1 bit 0) |
| therm_flag_o | output | 1 | Sticky thermal flag (reg 1 bit 1) |
| mute_l_o | output | 1 | Left mute (reg 2 bit 7) |
| mute_r_o | output | 1 | Right mute (reg 2 bit 6) |
| gain_o | output | 6 | Gain code (reg 2 bits 5:0) |
| float_l_o | output | 1 | Left output float (reg 3 bit 1) |
| float_r_o | output | 1 | Right output float (reg 3 bit 0) |

## Verification
The assertions assume that SDA changes only while SCL is low. They also assume that every SCL low and high phase lasts longer than the synchronizer delay plus one clock. Under those conditions a target drive change always lands inside a low phase. The bench master holds each bus phase for ten system clocks and moves SDA only after SCL has fallen. It also keeps the thermal input as a one-clock pulse that never coincides with a read of register 1.

// File: rtl/i2creg_pkg.sv
package i2creg_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_ADDR, S_ADDR_ACK, S_PTR, S_PTR_ACK,
      S_WDAT, S_WDAT_ACK, S_RDAT, S_RACK
   } tgt_state_e;

   localparam logic [7:0] A_CTRL = 8'd1;
   localparam logic [7:0] A_LVL  = 8'd2;
   localparam logic [7:0] A_FLT  = 8'd3;
   localparam logic [7:0] A_VER  = 8'd4;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int TOP = SYNC_STAGES;

   generate
      if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 2..4");
      end
   endgenerate

   // one stage beyond the synchronizer keeps the previous level
   logic [TOP:0] scl_pipe, sda_pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
      end else begin
         scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
         sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
      end
   end

   assign scl_lvl   = scl_pipe[TOP-1];
   assign sda_lvl   = sda_pipe[TOP-1];
   assign scl_rise  = scl_pipe[TOP-1] & ~scl_pipe[TOP];
   assign scl_fall  = ~scl_pipe[TOP-1] & scl_pipe[TOP];
   assign start_det = scl_pipe[TOP-1] & scl_pipe[TOP] & sda_pipe[TOP] & ~sda_pipe[TOP-1];
   assign stop_det  = scl_pipe[TOP-1] & scl_pipe[TOP] & ~sda_pipe[TOP] & sda_pipe[TOP-1];
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
   import i2creg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h60,
   parameter int         PTR_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_lvl,
   input  logic             sda_lvl,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [7:0]       rd_data,
   output logic [PTR_W-1:0] ptr,
   output logic             sda_pull,
   output logic             wr_stb,
   output logic [PTR_W-1:0] wr_addr,
   output logic [7:0]       wr_data,
   output logic             rd_stb,
   output logic [PTR_W-1:0] rd_stb_addr
);
   localparam int CNT_W = $clog2(8) + 1;

   generate
      if (PTR_W != 8) begin : g_bad_ptr
         $error("PTR_W must equal the 8-bit pointer byte");
      end
   endgenerate

   tgt_state_e       st;
   logic [7:0]       sh;
   logic [CNT_W-1:0] cnt;
   logic             rw, mack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; sh <= '0; cnt <= '0; rw <= 1'b0; mack <= 1'b0;
         ptr <= '0; sda_pull <= 1'b0;
         wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0;
         rd_stb <= 1'b0; rd_stb_addr <= '0;
      end else begin
         wr_stb <= 1'b0;
         rd_stb <= 1'b0;
         if (start_det) begin
            st <= S_ADDR; cnt <= '0; sda_pull <= 1'b0;
         end else if (stop_det) begin
            st <= S_IDLE; sda_pull <= 1'b0;
         end else begin
            case (st)
               S_ADDR, S_PTR, S_WDAT: begin
                  if (scl_rise) begin
                     sh  <= {sh[6:0], sda_lvl};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CNT_W'(8)) begin
                     cnt <= '0;
                     if (st == S_ADDR) begin
                        if (sh[7:1] == DEV_ADDR) begin
                           rw <= sh[0]; sda_pull <= 1'b1; st <= S_ADDR_ACK;
                        end else begin
                           st <= S_IDLE;
                        end
                     end else if (st == S_PTR) begin
                        ptr <= sh; sda_pull <= 1'b1; st <= S_PTR_ACK;
                     end else begin
                        wr_stb <= 1'b1; wr_addr <= ptr; wr_data <= sh;
                        sda_pull <= 1'b1; st <= S_WDAT_ACK;
                     end
                  end
               end
               S_ADDR_ACK, S_PTR_ACK, S_WDAT_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     if (st == S_WDAT_ACK) begin
                        ptr <= ptr + 1'b1; st <= S_WDAT;
                     end else if (st == S_PTR_ACK) begin
                        st <= S_WDAT;
                     end else if (rw) begin
                        sh <= rd_data; rd_stb <= 1'b1; rd_stb_addr <= ptr;
                        ptr <= ptr + 1'b1; sda_pull <= ~rd_data[7];
                        st <= S_RDAT;
                     end else begin
                        st <= S_PTR;
                     end
                  end
               end
               S_RDAT: begin
                  if (scl_fall) begin
                     if (cnt == CNT_W'(7)) begin
                        cnt <= '0; sda_pull <= 1'b0; st <= S_RACK;
                     end else begin
                        sh <= {sh[6:0], 1'b0}; sda_pull <= ~sh[6];
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               S_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (mack) begin
                        sh <= rd_data; rd_stb <= 1'b1; rd_stb_addr <= ptr;
                        ptr <= ptr + 1'b1; sda_pull <= ~rd_data[7];
                        st <= S_RDAT;
                     end else begin
                        st <= S_IDLE;
                     end
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   // R2 / R11: an idle target never holds the line
   p_idle_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE) |-> !sda_pull);
   // R2: the target only starts pulling while the sampled clock is low
   p_drive_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_lvl);
   // R4: a master NACK leaves the line released at the next clock fall
   p_nack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RACK && !mack && scl_fall && !start_det && !stop_det) |=> !sda_pull);
endmodule

// File: rtl/creg_bank.sv
module creg_bank
   import i2creg_pkg::*;
#(
   parameter logic [3:0] VERSION = 4'b0010,
   parameter int         PTR_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [PTR_W-1:0] wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [PTR_W-1:0] rd_addr,
   input  logic             rd_stb,
   input  logic [PTR_W-1:0] rd_stb_addr,
   input  logic             therm_evt,
   output logic [7:0]       rd_data,
   output logic             en_l,
   output logic             en_r,
   output logic [1:0]       mode,
   output logic             sws,
   output logic             therm,
   output logic             mute_l,
   output logic             mute_r,
   output logic [5:0]       gain,
   output logic             flt_l,
   output logic             flt_r
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_l <= 1'b0; en_r <= 1'b0; mode <= 2'b00; sws <= 1'b0;
         mute_l <= 1'b1; mute_r <= 1'b1; gain <= '0;
         flt_l <= 1'b0; flt_r <= 1'b0;
      end else if (wr_stb) begin
         case (wr_addr)
            A_CTRL: begin
               en_l <= wr_data[7] & ~wr_data[0];
               en_r <= wr_data[6] & ~wr_data[0];
               mode <= wr_data[5:4];
               sws  <= wr_data[0];
            end
            A_LVL: begin
               mute_l <= wr_data[7]; mute_r <= wr_data[6]; gain <= wr_data[5:0];
            end
            A_FLT: begin
               flt_l <= wr_data[1]; flt_r <= wr_data[0];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  therm <= 1'b0;
      else if (therm_evt)                          therm <= 1'b1;
      else if (rd_stb && rd_stb_addr == A_CTRL)    therm <= 1'b0;
   end

   always_comb begin
      case (rd_addr)
         A_CTRL:  rd_data = {en_l, en_r, mode, 2'b00, therm, sws};
         A_LVL:   rd_data = {mute_l, mute_r, gain};
         A_FLT:   rd_data = {6'b0, flt_l, flt_r};
         A_VER:   rd_data = {4'b0, VERSION};
         default: rd_data = 8'h00;
      endcase
   end

   p_sws_clears_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr == A_CTRL && wr_data[0]) |=> (!en_l && !en_r && sws));
   p_therm_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      therm_evt |=> therm);
   p_therm_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_stb_addr == A_CTRL && !therm_evt) |=> !therm);
   p_lvl_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr == A_LVL) |=> ({mute_l, mute_r, gain} == $past(wr_data)));
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
   parameter logic [6:0] DEV_ADDR    = 7'h60,
   parameter logic [3:0] VERSION     = 4'b0010,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       shdn_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_pull_o,
   input  logic       therm_evt_i,
   output logic       amp_en_l_o,
   output logic       amp_en_r_o,
   output logic [1:0] route_mode_o,
   output logic       soft_down_o,
   output logic       therm_flag_o,
   output logic       mute_l_o,
   output logic       mute_r_o,
   output logic [5:0] gain_o,
   output logic       float_l_o,
   output logic       float_r_o
);
   localparam int PTR_W = 8;

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic wr_stb, rd_stb;
   logic [PTR_W-1:0] ptr, wr_addr, rd_stb_addr;
   logic [7:0] wr_data, rd_data;

   i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
      .clk(clk), .rst_n(shdn_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det));

   i2c_target_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_fsm (
      .clk(clk), .rst_n(shdn_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
      .stop_det(stop_det), .rd_data(rd_data), .ptr(ptr), .sda_pull(sda_pull_o),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_stb(rd_stb), .rd_stb_addr(rd_stb_addr));

   creg_bank #(.VERSION(VERSION), .PTR_W(PTR_W)) u_bank (
      .clk(clk), .rst_n(shdn_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(ptr), .rd_stb(rd_stb),
      .rd_stb_addr(rd_stb_addr), .therm_evt(therm_evt_i), .rd_data(rd_data),
      .en_l(amp_en_l_o), .en_r(amp_en_r_o), .mode(route_mode_o),
      .sws(soft_down_o), .therm(therm_flag_o), .mute_l(mute_l_o),
      .mute_r(mute_r_o), .gain(gain_o), .flt_l(float_l_o), .flt_r(float_r_o));
endmodule

// File: tb/sim_i2c_regbank_target.sv
`timescale 1ns/1ps
module sim_i2c_regbank_target;
   localparam int HALF = 10;
   localparam logic [7:0] AW = 8'hC0, AR = 8'hC1;

   logic clk = 1'b0;
   logic shdn_n = 1'b0;
   logic scl = 1'b1, m_sda = 1'b1, therm = 1'b0;
   logic sda_pull, en_l, en_r, sws, tflag, mute_l, mute_r, fl_l, fl_r;
   logic [1:0] mode;
   logic [5:0] gain;
   logic sda_line;
   int checks = 0, failures = 0;

   always #2 clk = ~clk;
   assign sda_line = m_sda & ~sda_pull;

   i2c_regbank_target u0 (
      .clk(clk), .shdn_n(shdn_n), .scl_i(scl), .sda_i(sda_line),
      .sda_pull_o(sda_pull), .therm_evt_i(therm), .amp_en_l_o(en_l),
      .amp_en_r_o(en_r), .route_mode_o(mode), .soft_down_o(sws),
      .therm_flag_o(tflag), .mute_l_o(mute_l), .mute_r_o(mute_r),
      .gain_o(gain), .float_l_o(fl_l), .float_r_o(fl_r));

   // address, data written, expected readback
   localparam logic [23:0] VEC [10] = '{
      {8'd1, 8'hF6, 8'hF0},   // R5 reserved and flag bits masked
      {8'd1, 8'hC1, 8'h01},   // R9 low-power drops enables
      {8'd1, 8'h90, 8'h90},   // R3
      {8'd2, 8'h3F, 8'h3F},   // R3
      {8'd2, 8'h80, 8'h80},   // R3
      {8'd3, 8'hFF, 8'h03},   // R5
      {8'd3, 8'h01, 8'h01},   // R5
      {8'd4, 8'hFF, 8'h02},   // R6 read-only version
      {8'd0, 8'h55, 8'h00},   // R7
      {8'd6, 8'hAA, 8'h00}    // R7
   };

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hw();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; scl = 1'b1; hw(); m_sda = 1'b0; hw(); scl = 1'b0; hw();
   endtask

   task automatic bus_rstart();
      m_sda = 1'b1; hw(); scl = 1'b1; hw(); m_sda = 1'b0; hw(); scl = 1'b0; hw();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; hw(); scl = 1'b1; hw(); m_sda = 1'b1; hw();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; hw(); scl = 1'b1; hw(); scl = 1'b0;
      end
      m_sda = 1'b1; hw(); scl = 1'b1; hw(); ack = ~sda_line; scl = 1'b0; hw();
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      b = '0;
      m_sda = 1'b1;
      for (int i = 0; i < 8; i++) begin
         hw(); scl = 1'b1; hw(); b = {b[6:0], sda_line}; scl = 1'b0;
      end
      m_sda = ~mack; hw(); scl = 1'b1; hw(); scl = 1'b0; hw(); m_sda = 1'b1;
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      logic k;
      bus_start();
      send_byte(AW, k); chk("R2 addr ack", {7'b0, k}, 8'h01);
      send_byte(a, k);  chk("R2 ptr ack", {7'b0, k}, 8'h01);
      send_byte(d, k);  chk("R2 data ack", {7'b0, k}, 8'h01);
      bus_stop();
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
      logic k;
      bus_start();
      send_byte(AW, k); chk("R2 addr ack", {7'b0, k}, 8'h01);
      send_byte(a, k);  chk("R2 ptr ack", {7'b0, k}, 8'h01);
      bus_rstart();
      send_byte(AR, k); chk("R4 read addr ack", {7'b0, k}, 8'h01);
      recv_byte(1'b0, d);
      bus_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic k;
      repeat (5) @(negedge clk);
      shdn_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1 reset state at the ports
      chk("R1 ctrl outputs", {en_l, en_r, mode, 2'b00, tflag, sws}, 8'h00);
      chk("R1 level outputs", {mute_l, mute_r, gain}, 8'hC0);
      chk("R1 float outputs", {6'b0, fl_l, fl_r}, 8'h00);
      chk("R1 sda released", {7'b0, sda_pull}, 8'h00);
      rd_reg(8'd2, d); chk("R1 reg2 read", d, 8'hC0);
      rd_reg(8'd1, d); chk("R1 reg1 read", d, 8'h00);

      // vector table walk: single write then readback
      for (int v = 0; v < 10; v++) begin
         wr_reg(VEC[v][23:16], VEC[v][15:8]);
         rd_reg(VEC[v][23:16], d);
         chk($sformatf("R3/R5/R6/R7/R9 vector %0d", v), d, VEC[v][7:0]);
      end

      // R9 at the ports
      wr_reg(8'd1, 8'hC0);
      chk("R9 enables on", {6'b0, en_l, en_r}, 8'h03);
      wr_reg(8'd1, 8'hC1);
      chk("R9 enables dropped", {6'b0, en_l, en_r}, 8'h00);
      chk("R9 low-power set", {7'b0, sws}, 8'h01);

      // R3 burst write with auto-increment
      bus_start();
      send_byte(AW, k); send_byte(8'd1, k);
      send_byte(8'h20, k); send_byte(8'h7A, k);
      send_byte(8'h02, k); chk("R3 burst ack", {7'b0, k}, 8'h01);
      bus_stop();
      chk("R3 mode", {6'b0, mode}, 8'h02);
      chk("R3 level", {mute_l, mute_r, gain}, 8'h7A);
      chk("R3 float", {6'b0, fl_l, fl_r}, 8'h02);

      // R4 burst read until NACK
      bus_start();
      send_byte(AW, k); send_byte(8'd1, k);
      bus_rstart();
      send_byte(AR, k);
      recv_byte(1'b1, d); chk("R4 byte0", d, 8'h20);
      recv_byte(1'b1, d); chk("R4 byte1", d, 8'h7A);
      recv_byte(1'b1, d); chk("R4 byte2", d, 8'h02);
      recv_byte(1'b0, d); chk("R4 byte3", d, 8'h02);
      chk("R4 released after nack", {7'b0, sda_pull}, 8'h00);
      bus_stop();

      // R2 wrong device address
      bus_start();
      send_byte(8'hC2, k); chk("R2 mismatch no ack", {7'b0, k}, 8'h00);
      send_byte(8'd2, k);  chk("R2 mismatch ptr no ack", {7'b0, k}, 8'h00);
      send_byte(8'h00, k); chk("R2 mismatch data no ack", {7'b0, k}, 8'h00);
      bus_stop();
      chk("R2 level untouched", {mute_l, mute_r, gain}, 8'h7A);

      // R11 bytes after stop without start
      send_byte(AW, k); chk("R11 no ack without start", {7'b0, k}, 8'h00);
      send_byte(8'd2, k);
      send_byte(8'h11, k);
      bus_stop();
      chk("R11 level untouched", {mute_l, mute_r, gain}, 8'h7A);

      // R8 sticky thermal flag, cleared by read
      @(negedge clk); therm = 1'b1;
      @(negedge clk); therm = 1'b0;
      chk("R8 flag set", {7'b0, tflag}, 8'h01);
      wr_reg(8'd1, 8'h20);
      chk("R8 write keeps flag", {7'b0, tflag}, 8'h01);
      rd_reg(8'd1, d); chk("R8 first read", d, 8'h22);
      rd_reg(8'd1, d); chk("R8 second read", d, 8'h20);
      chk("R8 flag output clear", {7'b0, tflag}, 8'h00);

      // R10 shutdown
      @(negedge clk); shdn_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R10 level held", {mute_l, mute_r, gain}, 8'hC0);
      chk("R10 ctrl held", {en_l, en_r, mode, 2'b00, tflag, sws}, 8'h00);
      shdn_n = 1'b1;
      repeat (4) @(negedge clk);
      rd_reg(8'd2, d); chk("R10 reg2 after", d, 8'hC0);
      rd_reg(8'd3, d); chk("R10 reg3 after", d, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule